// File: doc/BRIEF.md
# Asynchronous ROM Read-Cycle Controller

This block sits on the clocked side of a chip and runs read cycles to an external asynchronous ROM. The ROM has an address bus, an active-low chip enable, an active-low output enable, a pin that selects 16-bit word or 8-bit byte organisation, and one extra low-order address pin that is used only in byte organisation. A client hands over one request at a time: a byte address and a flag that picks byte or word access. The controller drives the address, the mode pin and the enables. It waits a counted number of clock cycles so that the ROM's access limits are met, then captures the data bus and returns the result with a one-cycle valid pulse.

Every wait is derived from nanosecond parameters and the clock period by ceiling division. The address/chip-enable access time and the output-enable delay are combined so that sampling happens only after the latest of them has expired. After a capture, both enables are released together. A new request is refused until the ROM's output drivers have had time to float and the minimum read-cycle time since the previous address change has passed. With the default parameters (5 ns clock, 120 ns access and cycle time, 55 ns output-enable delay and float time), a read returns 24 clock edges after it is accepted, and the next request can be accepted 36 edges after the previous one.

Top module: `rom_read_ctrl`

## Requirements
- R1: While `rst` is high, `rom_ce_n` and `rom_oe_n` are 1 and `rsp_valid` and `req_ready` are 0, and this also holds when reset lands in the middle of a read; `req_ready` is 1 from the first clock edge at which `rst` is sampled low.
- R2: A request is taken only at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge on, and requests offered while it is 0 are dropped: they start no bus cycle and do not change the returned data.
- R3: At the accepting edge, `rom_addr`, `rom_lsb` and `rom_word_mode` are updated and `rom_ce_n` goes to 0. `rom_oe_n` goes to 0 one edge later. The address, LSB and mode outputs stay constant while `rom_ce_n` is 0, and `rom_oe_n` is never 0 while `rom_ce_n` is 1.
- R4: The data bus is sampled at accept edge + ACC, where ACC = max(ceil(max(t_addr, t_ce)/T), ceil(t_oe/T) + 1, 2) with T the clock period (24 with defaults). `rsp_valid` is 1 for exactly the one cycle that follows that edge.
- R5: Word access (`req_byte` = 0): `rom_word_mode` = 1, `rom_addr` = `req_addr[17:1]`, `rom_lsb` = 0 (bit 0 of `req_addr` is ignored), and `rsp_data` is the full 16-bit bus.
- R6: Byte access (`req_byte` = 1): `rom_word_mode` = 0, `rom_addr` = `req_addr[17:1]`, `rom_lsb` = `req_addr[0]`, and `rsp_data` = {8'h00, bus[7:0]}; bits 15:8 of the bus are discarded.
- R7: One edge after the sampling edge, `rom_ce_n` and `rom_oe_n` both return to 1. `rom_ce_n` then stays 1 for at least ceil(t_float/T) cycles (11 with defaults) before the next read.
- R8: `req_ready` returns to 1 at accept edge + max(ACC + ceil(t_float/T), ceil(t_rc/T) − 1, ACC + 2) (35 with defaults). Two accepts are therefore never closer than ceil(t_rc/T) edges.
- R9: `rsp_data` keeps the last captured value until the next sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client offers a read request |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | ADDR_W+1 (18) | Byte address; bit 0 selects the byte in byte access |
| rsp_valid | output | 1 | One-cycle pulse when `rsp_data` is new |
| rsp_data | output | DATA_W (16) | Read result, zero-extended for byte access |
| rom_addr | output | ADDR_W (17) | Word address to the ROM |
| rom_lsb | output | 1 | Extra low address bit, used in byte organisation |
| rom_word_mode | output | 1 | Organisation select to the ROM, 1 = 16-bit |
| rom_ce_n | output | 1 | Active-low chip enable |
| rom_oe_n | output | 1 | Active-low output enable |
| rom_dq | input | DATA_W (16) | ROM data bus |

## Verification
Each result has a fixed cycle offset from the accepting edge, and the bench samples it at the falling edge after that registered edge. The enables and address are checked one edge after acceptance, the output enable one edge later, the data pulse at edge 24 and its absence at edges 23 and 25, and `req_ready` at edges 34 and 35. The bench ROM model counts the cycles since the chip enable and the output enable fell. It puts a poison pattern on the bus until both access windows have elapsed, so a capture that comes too early returns wrong data. A separate monitor measures how long `rom_ce_n` stays high between reads.

// File: rtl/rom_rd_pkg.sv
`timescale 1ns/1ps
package rom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_WAIT    = 3'd2,
    ST_CAPTURE = 3'd3,
    ST_RELEASE = 3'd4
  } rd_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    return max2(max2(a, b), c);
  endfunction

endpackage

// File: rtl/rom_rd_timer.sv
`timescale 1ns/1ps
module rom_rd_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/rom_rd_fsm.sv
`timescale 1ns/1ps
module rom_rd_fsm
  import rom_rd_pkg::*;
#(
  parameter int WAIT_CYC = 23,
  parameter int REL_CYC  = 10,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             tmr_zero,
  output logic             accept,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             tmr_dec,
  output logic             ready,
  output logic             rsp_valid,
  output logic             ce_n,
  output logic             oe_n
);

  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] REL_LOAD  = CNT_W'(REL_CYC - 1);

  rd_state_t state_q;

  assign accept  = (state_q == ST_IDLE) && req_valid && ready;
  assign capture = (state_q == ST_WAIT) && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_SETUP: begin
        tmr_load = 1'b1;
        tmr_val  = WAIT_LOAD;
      end
      ST_CAPTURE: begin
        tmr_load = 1'b1;
        tmr_val  = REL_LOAD;
      end
      default: ;
    endcase
  end

  assign tmr_dec = (state_q == ST_WAIT) || (state_q == ST_RELEASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ready     <= 1'b0;
      rsp_valid <= 1'b0;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ce_n    <= 1'b0;
            ready   <= 1'b0;
            state_q <= ST_SETUP;
          end else begin
            ready <= 1'b1;
          end
        end
        ST_SETUP: begin
          oe_n    <= 1'b0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (tmr_zero) begin
            rsp_valid <= 1'b1;
            state_q   <= ST_CAPTURE;
          end
        end
        ST_CAPTURE: begin
          rsp_valid <= 1'b0;
          ce_n      <= 1'b1;
          oe_n      <= 1'b1;
          state_q   <= ST_RELEASE;
        end
        ST_RELEASE: begin
          if (tmr_zero) begin
            ready   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rom_rd_datapath.sv
`timescale 1ns/1ps
module rom_rd_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W:0]   req_addr,
  input  logic              req_byte,
  input  logic [DATA_W-1:0] rom_dq,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_lsb,
  output logic              rom_word_mode,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] cap_val;

  // Low lane passes through; upper lane is forced to zero in byte organisation.
  for (genvar b = 0; b < DATA_W; b++) begin : g_lane
    if (b < LANE_W) begin : g_low
      assign cap_val[b] = rom_dq[b];
    end else begin : g_high
      assign cap_val[b] = rom_dq[b] & rom_word_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr      <= '0;
      rom_lsb       <= 1'b0;
      rom_word_mode <= 1'b1;
      rsp_data      <= '0;
    end else begin
      if (accept) begin
        rom_addr      <= req_addr[ADDR_W:1];
        rom_lsb       <= req_byte & req_addr[0];
        rom_word_mode <= ~req_byte;
      end
      if (capture) begin
        rsp_data <= cap_val;
      end
    end
  end

endmodule

// File: rtl/rom_read_ctrl.sv
`timescale 1ns/1ps
module rom_read_ctrl
  import rom_rd_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_ADDR_NS     = 120,
  parameter int T_CE_NS       = 120,
  parameter int T_OE_NS       = 55,
  parameter int T_FLOAT_NS    = 55,
  parameter int T_RC_NS       = 120,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_byte,
  input  logic [ADDR_W:0]   req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_lsb,
  output logic              rom_word_mode,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  input  logic [DATA_W-1:0] rom_dq
);

  localparam int N_ACC    = ceil_div(max2(T_ADDR_NS, T_CE_NS), CLK_PERIOD_NS);
  localparam int N_OE     = ceil_div(T_OE_NS, CLK_PERIOD_NS);
  localparam int N_FLT    = ceil_div(T_FLOAT_NS, CLK_PERIOD_NS);
  localparam int N_CYC    = ceil_div(T_RC_NS, CLK_PERIOD_NS);
  localparam int WAIT_CYC = max3(N_OE, N_ACC - 1, 1);
  localparam int REL_CYC  = max3(N_FLT - 1, N_CYC - WAIT_CYC - 3, 1);
  localparam int CNT_W    = $clog2(max2(WAIT_CYC, REL_CYC) + 1);

  logic             accept;
  logic             capture;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_dec;
  logic             tmr_zero;

  rom_rd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  rom_rd_fsm #(
    .WAIT_CYC (WAIT_CYC),
    .REL_CYC  (REL_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .tmr_zero  (tmr_zero),
    .accept    (accept),
    .capture   (capture),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .tmr_dec   (tmr_dec),
    .ready     (req_ready),
    .rsp_valid (rsp_valid),
    .ce_n      (rom_ce_n),
    .oe_n      (rom_oe_n)
  );

  rom_rd_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk           (clk),
    .rst           (rst),
    .accept        (accept),
    .capture       (capture),
    .req_addr      (req_addr),
    .req_byte      (req_byte),
    .rom_dq        (rom_dq),
    .rom_addr      (rom_addr),
    .rom_lsb       (rom_lsb),
    .rom_word_mode (rom_word_mode),
    .rsp_data      (rsp_data)
  );

endmodule

// File: rtl/rom_read_ctrl_chk.sv
`timescale 1ns/1ps
module rom_read_ctrl_chk
  import rom_rd_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_ADDR_NS     = 120,
  parameter int T_CE_NS       = 120,
  parameter int T_OE_NS       = 55,
  parameter int T_FLOAT_NS    = 55,
  parameter int T_RC_NS       = 120,
  parameter int ADDR_W        = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              rom_lsb,
  input logic              rom_word_mode,
  input logic              rom_ce_n,
  input logic              rom_oe_n
);

  localparam int N_ACC = ceil_div(max2(T_ADDR_NS, T_CE_NS), CLK_PERIOD_NS);
  localparam int N_OE  = ceil_div(T_OE_NS, CLK_PERIOD_NS);
  localparam int N_FLT = ceil_div(T_FLOAT_NS, CLK_PERIOD_NS);
  localparam int N_CYC = ceil_div(T_RC_NS, CLK_PERIOD_NS);
  localparam logic [31:0] SAT = 32'h00FF_FFFF;

  logic [31:0] ce_cnt, oe_cnt, gap_cnt, cyc_cnt;
  logic        ce_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_cnt  <= '0;
      oe_cnt  <= '0;
      gap_cnt <= SAT;
      cyc_cnt <= SAT;
      ce_prev <= 1'b1;
    end else begin
      ce_prev <= rom_ce_n;
      ce_cnt  <= rom_ce_n ? '0 : ((ce_cnt < SAT) ? ce_cnt + 1 : ce_cnt);
      oe_cnt  <= rom_oe_n ? '0 : ((oe_cnt < SAT) ? oe_cnt + 1 : oe_cnt);
      gap_cnt <= !rom_ce_n ? '0 : ((gap_cnt < SAT) ? gap_cnt + 1 : gap_cnt);
      if (ce_prev && !rom_ce_n) cyc_cnt <= 32'd1;
      else if (cyc_cnt < SAT)   cyc_cnt <= cyc_cnt + 1;
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R4

  AST_ACC_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> (ce_cnt >= 32'(N_ACC))); // R4

  AST_OE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> (oe_cnt >= 32'(N_OE))); // R4

  AST_OE_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |-> !rom_ce_n); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!rom_ce_n && !$past(rom_ce_n)) |->
      ($stable(rom_addr) && $stable(rom_lsb) && $stable(rom_word_mode))); // R3

  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(rom_ce_n) |-> (gap_cnt >= 32'(N_FLT))); // R7

  AST_CYCLE_TIME: assert property (@(posedge clk) disable iff (rst)
    $fell(rom_ce_n) |-> (cyc_cnt >= 32'(N_CYC))); // R8

  AST_READY_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (rom_ce_n && !rsp_valid)); // R2

endmodule

bind rom_read_ctrl rom_read_ctrl_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .T_ADDR_NS     (T_ADDR_NS),
  .T_CE_NS       (T_CE_NS),
  .T_OE_NS       (T_OE_NS),
  .T_FLOAT_NS    (T_FLOAT_NS),
  .T_RC_NS       (T_RC_NS),
  .ADDR_W        (ADDR_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rom_addr      (rom_addr),
  .rom_lsb       (rom_lsb),
  .rom_word_mode (rom_word_mode),
  .rom_ce_n      (rom_ce_n),
  .rom_oe_n      (rom_oe_n)
);

// File: tb/rom_read_ctrl_bench.sv
`timescale 1ns/1ps
module rom_read_ctrl_bench;

  // Timing expectations from the requirements, default parameters, 5 ns clock.
  localparam int T_NS       = 5;
  localparam int NA         = (120 + T_NS - 1) / T_NS;       // 24
  localparam int NO         = (55 + T_NS - 1) / T_NS;        // 11
  localparam int NF         = (55 + T_NS - 1) / T_NS;        // 11
  localparam int NC         = (120 + T_NS - 1) / T_NS;       // 24
  localparam int ACC_EDGE   = (NA > NO + 1) ? NA : NO + 1;   // 24
  localparam int RDY_A      = ACC_EDGE + NF;
  localparam int RDY_B      = (NC - 1 > ACC_EDGE + 2) ? NC - 1 : ACC_EDGE + 2;
  localparam int READY_EDGE = (RDY_A > RDY_B) ? RDY_A : RDY_B; // 35

  // Stimulus table: {req_byte, req_addr}
  localparam int NVEC = 8;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 18'h00000},
    {1'b0, 18'h3FFFE},
    {1'b0, 18'h12345},
    {1'b1, 18'h00000},
    {1'b1, 18'h00001},
    {1'b1, 18'h3FFFF},
    {1'b1, 18'h2AAAA},
    {1'b0, 18'h15555}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_byte = 1'b0;
  logic [17:0] req_addr = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic [16:0] rom_addr;
  logic        rom_lsb, rom_word_mode, rom_ce_n, rom_oe_n;
  logic [15:0] rom_dq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rom_read_ctrl u_rom_read_ctrl (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_byte (req_byte), .req_addr (req_addr),
    .rsp_valid (rsp_valid), .rsp_data (rsp_data),
    .rom_addr (rom_addr), .rom_lsb (rom_lsb), .rom_word_mode (rom_word_mode),
    .rom_ce_n (rom_ce_n), .rom_oe_n (rom_oe_n), .rom_dq (rom_dq)
  );

  function automatic logic [15:0] rom_word(input logic [16:0] a);
    return 16'(a[15:0] * 16'd7919) ^ {15'd0, a[16]} ^ 16'h5AC3;
  endfunction

  function automatic logic [15:0] expect_data(input logic bm, input logic [17:0] a);
    logic [15:0] w;
    w = rom_word(a[17:1]);
    if (!bm) return w;
    return {8'h00, (a[0] ? w[15:8] : w[7:0])};
  endfunction

  // ROM model: poison on the bus until both access windows have run out.
  int          acc_cnt = 0;
  int          oe_cnt = 0;
  logic        prev_ce = 1'b1, prev_oe = 1'b1;
  logic [16:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rom_ce_n) acc_cnt <= 0;
    else if (prev_ce || rom_addr != prev_addr) acc_cnt <= 1;
    else acc_cnt <= acc_cnt + 1;
    if (rom_oe_n) oe_cnt <= 0;
    else if (prev_oe) oe_cnt <= 1;
    else oe_cnt <= oe_cnt + 1;
    prev_ce   <= rom_ce_n;
    prev_oe   <= rom_oe_n;
    prev_addr <= rom_addr;
  end

  always_comb begin
    logic [15:0] w;
    w = rom_word(rom_addr);
    if (rom_ce_n || rom_oe_n)             rom_dq = 16'hBAD0;
    else if (acc_cnt < NA || oe_cnt < NO) rom_dq = 16'hDEAD;
    else if (rom_word_mode)               rom_dq = w;
    else                                  rom_dq = {8'hEE, (rom_lsb ? w[15:8] : w[7:0])};
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Float-gap monitor: cycles with chip enable high before each new read.
  int gap = 1000;
  always @(negedge clk) begin
    if (rst) gap <= 1000;
    else if (rom_ce_n) gap <= gap + 1;
    else begin
      if (gap != 0) chk("R7 float gap before read", 32'(gap >= NF), 32'd1);
      gap <= 0;
    end
  end

  task automatic do_read(input logic bm, input logic [17:0] a, input bit poke_busy);
    logic [15:0] exp;
    exp = expect_data(bm, a);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_byte = bm; req_addr = a;
    @(posedge clk);                       // accepting edge E0
    @(negedge clk);
    if (poke_busy) begin
      req_addr = a ^ 18'h0F0F0; req_byte = ~bm;   // R2: offered while busy
    end else req_valid = 1'b0;
    chk("R2 ready low after accept", 32'(req_ready), 32'd0);
    chk("R3 ce low at accept+1", 32'(rom_ce_n), 32'd0);
    chk("R3 oe still high at accept+1", 32'(rom_oe_n), 32'd1);
    chk("R3 rom_addr", 32'(rom_addr), 32'(a[17:1]));
    chk(bm ? "R6 byte lsb pin" : "R5 word lsb pin zero", 32'(rom_lsb), 32'(bm & a[0]));
    chk(bm ? "R6 mode pin byte" : "R5 mode pin word", 32'(rom_word_mode), 32'(!bm));
    @(negedge clk);
    chk("R3 oe low one edge after ce", 32'(rom_oe_n), 32'd0);
    repeat (ACC_EDGE - 2) @(negedge clk);
    req_valid = 1'b0;
    chk("R4 no response before access window", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk("R4 response pulse at access edge", 32'(rsp_valid), 32'd1);
    chk(bm ? "R6 byte data zero-extended" : "R5 word data", 32'(rsp_data), 32'(exp));
    @(negedge clk);
    chk("R4 pulse lasts one cycle", 32'(rsp_valid), 32'd0);
    chk("R7 ce released", 32'(rom_ce_n), 32'd1);
    chk("R7 oe released", 32'(rom_oe_n), 32'd1);
    chk("R9 data held", 32'(rsp_data), 32'(exp));
    repeat (READY_EDGE - ACC_EDGE - 2) @(negedge clk);
    chk("R8 ready low before cycle end", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk("R8 ready high at cycle end", 32'(req_ready), 32'd1);
    chk("R9 data held until next read", 32'(rsp_data), 32'(exp));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset ce", 32'(rom_ce_n), 32'd1);
    chk("R1 reset oe", 32'(rom_oe_n), 32'd1);
    chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 reset ready", 32'(req_ready), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      do_read(VEC[i][18], VEC[i][17:0], 1'b0);
    end

    // R2: request offered throughout a busy read is dropped
    do_read(1'b0, 18'h0ABCC, 1'b1);
    repeat (5) @(negedge clk);
    chk("R2 busy request started no cycle", 32'(rom_ce_n), 32'd1);
    chk("R2 busy request left data", 32'(rsp_data), 32'(expect_data(1'b0, 18'h0ABCC)));

    // R1: reset in the middle of a read
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_byte = 1'b0; req_addr = 18'h01234;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-read reset ce", 32'(rom_ce_n), 32'd1);
    chk("R1 mid-read reset oe", 32'(rom_oe_n), 32'd1);
    chk("R1 mid-read reset ready", 32'(req_ready), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after mid-read reset", 32'(req_ready), 32'd1);
    repeat (NF) @(negedge clk);

    // Boundary: back-to-back byte reads of both halves of the top word
    do_read(1'b1, 18'h3FFFE, 1'b0);
    do_read(1'b1, 18'h3FFFF, 1'b0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule